// File: doc/BRIEF.md
# Dual-PHY Test-Port Parameter Sequencer

This block updates configuration bits inside one or two serial-link PHYs. It reaches them through a shared indirect test port made of two bus words. The outgoing command word carries a data byte, a register address and a write-enable flag. The incoming read word returns the selected register's contents. The second PHY uses the upper 16-bit lane of both words.

A request names a PHY, a 5-bit register address, an 8-bit mask and an 8-bit parameter value. The block then performs a masked read-modify-write. It issues a read command and samples the old value. It writes the merged value with a low/high/low write-enable pattern. It finishes with a read command whose result is discarded. Every command write is followed by two settling reads.

A batch request walks a fixed list of four register updates. The list is applied to PHY 0 alone, or to PHY 0 and then to PHY 1. Bus accesses are one-cycle strobes, and each one waits for an acknowledge before the next access starts.

Top module: `phy_tport_seq`

## Requirements
- R1: For PHY 0 a command word carries the data byte in bits 13:6, the register address in bits 5:1 and write-enable in bit 0. Bits 31:14 are zero.
- R2: For PHY 1 the same 14-bit command is placed 16 bits higher, with bits 15:0 and 31:30 zero. The read value is taken from read-word bits 23:16.
- R3: For PHY 0 the old value is read-word bits 7:0, and all other read-word bits have no effect on the result.
- R4: Every command write is followed by at least two read strobes before the next command write.
- R5: A request starts with a read command (data field 1, write-enable 0, target address) followed by three reads. The value returned on the third read is the old value.
- R6: The new value is (old AND NOT mask) OR (param AND mask). It is written as three command words carrying that value, with write-enable 0, then 1, then 0, each followed by two reads.
- R7: After the update, one more read command to the same address is issued, followed by three reads. The value of the last of these reads is discarded.
- R8: Each strobe lasts one cycle. No further strobe is issued until bus_ack has been seen, whatever the acknowledge delay.
- R9: A batch request updates addresses 0, 6, 26 and 28 in that order. The masks are 0x01, 0x1E, 0xC0 and 0x30, and the params are 0x01, 0x0A, 0x40 and 0x20. The list is applied to PHY 0 only, or, with req_dual set, to PHY 0 and then PHY 1.
- R10: busy rises in the cycle after an accepted request and falls after the final acknowledge, together with a one-cycle done pulse. A request raised while busy is ignored and causes no bus access.
- R11: In reset and after it, busy, done, bus_wr and bus_rd are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, accepted when not busy |
| req_batch | input | 1 | Run the fixed four-entry list instead of a single update |
| req_dual | input | 1 | In batch mode also apply the list to PHY 1 |
| req_phy | input | 1 | PHY index for a single update |
| req_adr | input | 5 | Register address for a single update |
| req_mask | input | 8 | Bits to change |
| req_param | input | 8 | New bit values |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| bus_wr | output | 1 | Write strobe for the command word |
| bus_rd | output | 1 | Read strobe for the read word |
| bus_wdata | output | 32 | Command word |
| bus_rdata | input | 32 | Read word, valid with bus_ack |
| bus_ack | input | 1 | Access acknowledge |

## Verification
A strobe is due one cycle after the edge that accepts a request, or one cycle after the edge that samples an acknowledge. busy is due one cycle after acceptance. done is due in the cycle after the edge that samples the last acknowledge. The bench drives inputs and samples outputs on falling edges, so each result is read in the cycle it is due. The bus model varies the acknowledge delay between one and three cycles and checks that no strobe appears while it is waiting. Every access is compared in order against a queue that the driver fills from the requirements. The PHY model places junk in the unused read-word bits, so any lane or masking error shows up in later written values.

// File: rtl/tport_pkg.sv
package tport_pkg;
    localparam int DAT_W     = 8;
    localparam int ADR_W     = 5;
    localparam int NUM_ENT   = 4;
    localparam int ENT_W     = $clog2(NUM_ENT);
    localparam int ITEM_W    = ENT_W + 1;
    localparam int NUM_STEPS = 17;
    localparam int STEP_W    = $clog2(NUM_STEPS);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT
    } seq_st_e;

    typedef struct packed {
        seq_st_e             st;
        logic [STEP_W-1:0]   step;
        logic [ITEM_W-1:0]   item;
        logic                batch;
        logic                dual;
        logic                phy;
        logic [ADR_W-1:0]    adr;
        logic [DAT_W-1:0]    mask;
        logic [DAT_W-1:0]    param;
        logic [DAT_W-1:0]    old;
        logic                done;
    } seq_q_t;
endpackage

// File: rtl/tport_word_fmt.sv
module tport_word_fmt
    import tport_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int LANE_SHIFT = 16
) (
    input  logic              phy,
    input  logic [DAT_W-1:0]  dat,
    input  logic [ADR_W-1:0]  adr,
    input  logic              we,
    input  logic [WORD_W-1:0] rword,
    output logic [WORD_W-1:0] word,
    output logic [DAT_W-1:0]  rdat
);
    localparam int CMD_W = DAT_W + ADR_W + 1;

    logic [CMD_W-1:0] cmd;

    always_comb begin
        cmd  = {dat, adr, we};
        word = phy ? (WORD_W'(cmd) << LANE_SHIFT) : WORD_W'(cmd);
        rdat = phy ? rword[LANE_SHIFT +: DAT_W] : rword[DAT_W-1:0];
    end
endmodule

// File: rtl/tport_batch_tbl.sv
module tport_batch_tbl
    import tport_pkg::*;
#(
    parameter logic [NUM_ENT-1:0][ADR_W-1:0] ADR_TBL   = {5'd28, 5'd26, 5'd6, 5'd0},
    parameter logic [NUM_ENT-1:0][DAT_W-1:0] MASK_TBL  = {8'h30, 8'hC0, 8'h1E, 8'h01},
    parameter logic [NUM_ENT-1:0][DAT_W-1:0] PARAM_TBL = {8'h20, 8'h40, 8'h0A, 8'h01}
) (
    input  logic [ENT_W-1:0] idx,
    output logic [ADR_W-1:0] adr,
    output logic [DAT_W-1:0] mask,
    output logic [DAT_W-1:0] param
);
    always_comb begin
        adr   = ADR_TBL[idx];
        mask  = MASK_TBL[idx];
        param = PARAM_TBL[idx];
    end
endmodule

// File: rtl/tport_rmw_fsm.sv
module tport_rmw_fsm
    import tport_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_batch,
    input  logic             start_dual,
    input  logic             start_phy,
    input  logic [ADR_W-1:0] start_adr,
    input  logic [DAT_W-1:0] start_mask,
    input  logic [DAT_W-1:0] start_param,
    output logic [ENT_W-1:0] tbl_idx,
    input  logic [ADR_W-1:0] tbl_adr,
    input  logic [DAT_W-1:0] tbl_mask,
    input  logic [DAT_W-1:0] tbl_param,
    input  logic             bus_ack,
    input  logic [DAT_W-1:0] rd_dat,
    output logic             cur_phy,
    output logic [ADR_W-1:0] cur_adr,
    output logic [DAT_W-1:0] cur_dat,
    output logic             cur_we,
    output logic             bus_wr,
    output logic             bus_rd,
    output logic             busy,
    output logic             done
);
    localparam logic [STEP_W-1:0] STEP_CAP  = STEP_W'(3);
    localparam logic [STEP_W-1:0] STEP_WE   = STEP_W'(7);
    localparam logic [STEP_W-1:0] STEP_TAIL = STEP_W'(13);
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(NUM_STEPS - 1);

    seq_q_t q, d;

    logic             step_is_wr;
    logic             step_rdcmd;
    logic [DAT_W-1:0] t_mask, t_param, new_val;
    logic [ITEM_W-1:0] last_item;

    always_comb begin
        d      = q;
        d.done = 1'b0;

        t_mask     = q.batch ? tbl_mask  : q.mask;
        t_param    = q.batch ? tbl_param : q.param;
        new_val    = (q.old & ~t_mask) | (t_param & t_mask);
        step_is_wr = (q.step == STEP_W'(0)) || (q.step == STEP_W'(4)) ||
                     (q.step == STEP_WE)    || (q.step == STEP_W'(10)) ||
                     (q.step == STEP_TAIL);
        step_rdcmd = (q.step < STEP_W'(4)) || (q.step >= STEP_TAIL);
        last_item  = q.dual ? ITEM_W'(2*NUM_ENT-1) : ITEM_W'(NUM_ENT-1);

        tbl_idx = q.item[ENT_W-1:0];
        cur_phy = q.batch ? q.item[ITEM_W-1] : q.phy;
        cur_adr = q.batch ? tbl_adr : q.adr;
        cur_dat = step_rdcmd ? DAT_W'(1) : new_val;
        cur_we  = (q.step == STEP_WE);

        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st    = ST_ISSUE;
                    d.step  = '0;
                    d.item  = '0;
                    d.batch = start_batch;
                    d.dual  = start_batch & start_dual;
                    d.phy   = start_phy;
                    d.adr   = start_adr;
                    d.mask  = start_mask;
                    d.param = start_param;
                end
            end
            ST_ISSUE: d.st = ST_WAIT;
            ST_WAIT: begin
                if (bus_ack) begin
                    if (q.step == STEP_CAP) d.old = rd_dat;
                    if (q.step == STEP_LAST) begin
                        d.step = '0;
                        if (q.batch && (q.item != last_item)) begin
                            d.item = q.item + ITEM_W'(1);
                            d.st   = ST_ISSUE;
                        end else begin
                            d.st   = ST_IDLE;
                            d.done = 1'b1;
                        end
                    end else begin
                        d.step = q.step + STEP_W'(1);
                        d.st   = ST_ISSUE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase

        bus_wr = (q.st == ST_ISSUE) &&  step_is_wr;
        bus_rd = (q.st == ST_ISSUE) && !step_is_wr;
        busy   = (q.st != ST_IDLE);
        done   = q.done;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // read-after-write tracking for the checks below
    logic [1:0] rd_seen_q;
    logic       wr_open_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_seen_q <= '0;
            wr_open_q <= 1'b0;
        end else if (bus_wr) begin
            rd_seen_q <= '0;
            wr_open_q <= 1'b1;
        end else begin
            if (bus_rd && rd_seen_q != 2'd3) rd_seen_q <= rd_seen_q + 2'd1;
            if (!busy) wr_open_q <= 1'b0;
        end
    end

    // R4
    settle_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && wr_open_q) |-> (rd_seen_q >= 2'd2));

    // R7
    tail_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rd_seen_q == 2'd3));

    // R8
    one_cycle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr || bus_rd) |=> !(bus_wr || bus_rd));

    // R8
    done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bus_ack));
endmodule

// File: rtl/phy_tport_seq.sv
module phy_tport_seq
    import tport_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int LANE_SHIFT = 16,
    parameter logic [NUM_ENT-1:0][ADR_W-1:0] ADR_TBL   = {5'd28, 5'd26, 5'd6, 5'd0},
    parameter logic [NUM_ENT-1:0][DAT_W-1:0] MASK_TBL  = {8'h30, 8'hC0, 8'h1E, 8'h01},
    parameter logic [NUM_ENT-1:0][DAT_W-1:0] PARAM_TBL = {8'h20, 8'h40, 8'h0A, 8'h01}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_batch,
    input  logic              req_dual,
    input  logic              req_phy,
    input  logic [ADR_W-1:0]  req_adr,
    input  logic [DAT_W-1:0]  req_mask,
    input  logic [DAT_W-1:0]  req_param,
    output logic              busy,
    output logic              done,
    output logic              bus_wr,
    output logic              bus_rd,
    output logic [WORD_W-1:0] bus_wdata,
    input  logic [WORD_W-1:0] bus_rdata,
    input  logic              bus_ack
);
    logic [ENT_W-1:0] tbl_idx;
    logic [ADR_W-1:0] tbl_adr, cur_adr;
    logic [DAT_W-1:0] tbl_mask, tbl_param, cur_dat, rd_dat;
    logic             cur_phy, cur_we;

    tport_batch_tbl #(
        .ADR_TBL  (ADR_TBL),
        .MASK_TBL (MASK_TBL),
        .PARAM_TBL(PARAM_TBL)
    ) u_tbl (
        .idx  (tbl_idx),
        .adr  (tbl_adr),
        .mask (tbl_mask),
        .param(tbl_param)
    );

    tport_rmw_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (req_valid),
        .start_batch(req_batch),
        .start_dual (req_dual),
        .start_phy  (req_phy),
        .start_adr  (req_adr),
        .start_mask (req_mask),
        .start_param(req_param),
        .tbl_idx    (tbl_idx),
        .tbl_adr    (tbl_adr),
        .tbl_mask   (tbl_mask),
        .tbl_param  (tbl_param),
        .bus_ack    (bus_ack),
        .rd_dat     (rd_dat),
        .cur_phy    (cur_phy),
        .cur_adr    (cur_adr),
        .cur_dat    (cur_dat),
        .cur_we     (cur_we),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .busy       (busy),
        .done       (done)
    );

    tport_word_fmt #(
        .WORD_W    (WORD_W),
        .LANE_SHIFT(LANE_SHIFT)
    ) u_fmt (
        .phy  (cur_phy),
        .dat  (cur_dat),
        .adr  (cur_adr),
        .we   (cur_we),
        .rword(bus_rdata),
        .word (bus_wdata),
        .rdat (rd_dat)
    );

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(bus_wr || bus_rd));

    // R10
    done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/phy_tport_seq_test.sv
module phy_tport_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_batch = 1'b0, req_dual = 1'b0, req_phy = 1'b0;
    logic [4:0]  req_adr = '0;
    logic [7:0]  req_mask = '0, req_param = '0;
    logic        busy, done, bus_wr, bus_rd;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;

    always #4 clk = ~clk;

    phy_tport_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_batch(req_batch),
        .req_dual(req_dual), .req_phy(req_phy), .req_adr(req_adr),
        .req_mask(req_mask), .req_param(req_param), .busy(busy), .done(done),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    typedef struct {
        bit          is_wr;
        logic [31:0] wdata;
        int          phy;
        string       tag;
    } acc_t;

    acc_t        expq[$];
    int          checks = 0, errors = 0;
    int          dones_exp = 0, dones_seen = 0;
    logic [7:0]  shadow [2][32];
    logic [7:0]  mregs  [2][32];
    logic [4:0]  last_adr [2];
    logic [4:0]  b_adr   [4] = '{5'd0, 5'd6, 5'd26, 5'd28};
    logic [7:0]  b_mask  [4] = '{8'h01, 8'h1E, 8'hC0, 8'h30};
    logic [7:0]  b_param [4] = '{8'h01, 8'h0A, 8'h40, 8'h20};

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mkword(int p, logic [7:0] d, logic [4:0] a, bit we);
        logic [31:0] w;
        w = {18'd0, d, a, we};
        if (p != 0) w = w << 16;
        return w;
    endfunction

    task automatic push_acc(bit w, logic [31:0] d, int p, string t);
        acc_t it;
        it.is_wr = w; it.wdata = d; it.phy = p; it.tag = t;
        expq.push_back(it);
    endtask

    task automatic push_update(int p, logic [4:0] a, logic [7:0] m, logic [7:0] prm, string rq);
        logic [7:0]  nv;
        logic [31:0] rc, w0, w1;
        nv = (shadow[p][a] & ~m) | (prm & m);
        rc = mkword(p, 8'd1, a, 1'b0);
        w0 = mkword(p, nv, a, 1'b0);
        w1 = mkword(p, nv, a, 1'b1);
        push_acc(1, rc, p, {rq, " R5 read cmd"});
        push_acc(0, '0, p, {rq, " R4 settle"});
        push_acc(0, '0, p, {rq, " R4 settle"});
        push_acc(0, '0, p, {rq, " R3 sample"});
        push_acc(1, w0, p, {rq, " R6 write we0"});
        push_acc(0, '0, p, {rq, " R4 settle"});
        push_acc(0, '0, p, {rq, " R4 settle"});
        push_acc(1, w1, p, {rq, " R6 write we1"});
        push_acc(0, '0, p, {rq, " R4 settle"});
        push_acc(0, '0, p, {rq, " R4 settle"});
        push_acc(1, w0, p, {rq, " R6 write we0 again"});
        push_acc(0, '0, p, {rq, " R4 settle"});
        push_acc(0, '0, p, {rq, " R4 settle"});
        push_acc(1, rc, p, {rq, " R7 trailing cmd"});
        push_acc(0, '0, p, {rq, " R4 settle"});
        push_acc(0, '0, p, {rq, " R4 settle"});
        push_acc(0, '0, p, {rq, " R7 dummy read"});
        shadow[p][a] = nv;
    endtask

    task automatic send(bit b, bit dl, bit p, logic [4:0] a, logic [7:0] m, logic [7:0] prm, string rq);
        @(negedge clk);
        while (busy) @(negedge clk);
        if (b) begin
            for (int ph = 0; ph < (dl ? 2 : 1); ph++)
                for (int e = 0; e < 4; e++)
                    push_update(ph, b_adr[e], b_mask[e], b_param[e], rq);
        end else begin
            push_update(int'(p), a, m, prm, rq);
        end
        req_batch = b; req_dual = dl; req_phy = p;
        req_adr = a; req_mask = m; req_param = prm;
        req_valid = 1'b1;
        dones_exp++;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R10", "busy after accept", 32'(busy), 32'd1);
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R10", "done lasts one cycle", 32'(done), 32'd0);
        chk(busy == 1'b0, "R10", "busy low after done", 32'(busy), 32'd0);
    endtask

    // bus and PHY model with scoreboard compare
    initial begin
        int ackcnt;
        int rphy;
        ackcnt = 0;
        rphy = 0;
        forever begin
            @(negedge clk);
            if (rst_n && (bus_wr || bus_rd)) begin
                chk(!(bus_wr && bus_rd), "R8", "single strobe", {bus_wr, bus_rd}, 32'd0);
                if (expq.size() == 0) begin
                    chk(1'b0, "R10", "unexpected access", bus_wdata, 32'd0);
                end else begin
                    acc_t it;
                    it = expq.pop_front();
                    rphy = it.phy;
                    chk(bus_wr == it.is_wr, it.tag, "access kind", 32'(bus_wr), 32'(it.is_wr));
                    if (bus_wr) begin
                        logic [15:0] lane;
                        chk(bus_wdata == it.wdata, it.tag, "command word", bus_wdata, it.wdata);
                        lane = (it.phy != 0) ? bus_wdata[31:16] : bus_wdata[15:0];
                        last_adr[it.phy] = lane[5:1];
                        if (lane[0]) mregs[it.phy][lane[5:1]] = lane[13:6];
                    end
                end
                repeat (1 + (ackcnt % 3)) begin
                    @(negedge clk);
                    chk(!(bus_wr || bus_rd), "R8", "no strobe before ack", {bus_wr, bus_rd}, 32'd0);
                end
                ackcnt++;
                if (rphy != 0)
                    bus_rdata = {8'h96, mregs[1][last_adr[1]], 8'h69, 8'hF0};
                else
                    bus_rdata = {8'h5A, 8'h3C, 8'hC3, mregs[0][last_adr[0]]};
                bus_ack = 1'b1;
                @(posedge clk);
                #1 bus_ack = 1'b0;
            end
        end
    end

    // done monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                dones_seen++;
                chk(expq.size() == 0, "R10", "done after last access",
                    32'(expq.size()), 32'd0);
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int p = 0; p < 2; p++) begin
            last_adr[p] = '0;
            for (int a = 0; a < 32; a++) begin
                shadow[p][a] = 8'(a * 7 + p * 40 + 3);
                mregs[p][a]  = 8'(a * 7 + p * 40 + 3);
            end
        end
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R11", "busy in reset", 32'(busy), 32'd0);
        chk(done == 1'b0, "R11", "done in reset", 32'(done), 32'd0);
        chk(!(bus_wr || bus_rd), "R11", "strobes in reset", {bus_wr, bus_rd}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy == 1'b0, "R11", "busy after reset", 32'(busy), 32'd0);

        send(0, 0, 0, 5'd6, 8'hF0, 8'hA5, "R1");
        wait_done();
        send(0, 0, 1, 5'd17, 8'h0F, 8'h3C, "R2");
        wait_done();
        send(0, 0, 0, 5'd31, 8'h00, 8'hFF, "R6 zero-mask");
        wait_done();
        send(0, 0, 1, 5'd0, 8'hFF, 8'h81, "R2 full-mask");
        wait_done();
        send(1, 0, 0, 5'd0, 8'h00, 8'h00, "R9 single");
        wait_done();
        send(1, 1, 0, 5'd0, 8'h00, 8'h00, "R9 dual");
        repeat (10) @(negedge clk);
        req_phy = 1'b1; req_adr = 5'd9; req_mask = 8'hFF; req_param = 8'h00;
        req_batch = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R10", "still busy during ignored request", 32'(busy), 32'd1);
        wait_done();
        repeat (30) @(negedge clk);
        chk(busy == 1'b0, "R10", "ignored request left idle", 32'(busy), 32'd0);
        chk(expq.size() == 0, "R10", "queue drained", 32'(expq.size()), 32'd0);
        chk(dones_seen == dones_exp, "R10", "done count", 32'(dones_seen), 32'(dones_exp));

        for (int p = 0; p < 2; p++)
            for (int a = 0; a < 32; a++)
                chk(mregs[p][a] == shadow[p][a], "R6", $sformatf("phy%0d reg%0d", p, a),
                    32'(mregs[p][a]), 32'(shadow[p][a]));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule